// File: doc/BRIEF.md
# Power Island Switch Sequencer

This block switches one power island on and off in hardware. Software issues commands through a small write-only register port. Every write must carry a key in its top byte, and a write without the key is dropped. When a power-on command is accepted, the sequencer closes the power switches at the lowest inrush-current limit. It waits a programmable number of cycles for the power-good input. If power-good does not arrive in that time, it raises the limit one step and waits again. Once the island reports good power, the sequencer releases electrical isolation, requests memory repair and waits a bounded time for repair-done. Releasing functional isolation is the last step.

A power-off command runs the reverse path: functional isolation first, then electrical isolation, then the switches open. A failed wait undoes the steps already taken. It then issues an error pulse together with a code that names the step that timed out. A command that arrives while a sequence is running is dropped and sets a sticky collision flag.

Register port: address 0 is the command word (bit 0 power on, bit 1 power off, bit 2 clear collision flag). Address 1 holds the power-good wait length in cycles. Address 2 holds the repair wait length in cycles. Both lengths sit in the low bits of the written word.

Top module: `pwr_island_seq`

## Requirements
- R1: A write takes effect only if bits 31:24 of the written word equal 0x5A. A write with any other top byte leaves the commands, the timeouts and the collision flag unchanged.
- R2: A power-on command while the switch enable is already high issues a done pulse in the next cycle. It starts no sequence and leaves every island output unchanged.
- R3: Power-on starts at inrush level 0, with levels coded 0 to 3 from lowest to highest current. Without power-good, each level holds for (power-good timeout + 1) cycles and then steps up by one.
- R4: If power-good is still absent when level 3 expires, the switch enable and the inrush level return to 0. The error pulse fires with fail code 1.
- R5: One cycle after power-good is sampled, electrical isolation is released. The repair request rises one cycle after that.
- R6: When repair-done is sampled, the repair request falls, functional isolation is released and the done pulse fires, all in the same cycle.
- R7: If repair-done is absent for (repair timeout + 1) cycles, the repair request falls and electrical isolation is reasserted. The switch and the inrush level are cleared, and the error pulse fires with fail code 2.
- R8: Power-off takes three cycles. Functional isolation is asserted first, electrical isolation in the next cycle, and the switch opens with the done pulse in the cycle after that. The switch opens with the inrush level at 0.
- R9: A command received while busy is ignored and sets the collision flag. The flag stays set until a keyed write with command bit 2 clears it. If bits 0 and 1 are set together while idle, the command is treated as power-off.
- R10: Power-good sampled in the very cycle that the current inrush level's wait expires counts as success.
- R11: Done and error are single-cycle pulses and are never high together.
- R12: After reset all island outputs, busy, done, error, fail code and collision flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Write data, key in bits 31:24 |
| pwr_good | input | 1 | Island supply reports good power |
| repair_done | input | 1 | Memory repair finished |
| sw_enable | output | 1 | Close power switches |
| inrush_lvl | output | 2 | Inrush current limit level |
| eiso_release | output | 1 | Electrical isolation released |
| fiso_release | output | 1 | Functional isolation released |
| repair_req | output | 1 | Memory repair request |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | Sequence finished pulse |
| seq_error | output | 1 | Sequence failed pulse |
| fail_step | output | 2 | 0 none, 1 power-good timeout, 2 repair timeout |
| collide | output | 1 | Sticky collision flag |

## Verification
Two events can land in the same cycle. The first is power-good and the expiry of the current inrush wait. The bench's supply model asserts power-good exactly when the wait counter reaches its limit, and the sequence must end in success at that level, not by stepping up. The second is the end of a sequence and a new command. The bench drives a keyed power-off in the cycle when repair-done is sampled. It expects the on-sequence to finish with a done pulse, the collision flag to be set, and the island to stay powered.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam logic [7:0] WR_KEY = 8'h5A;
  localparam int CMD_ON  = 0;
  localparam int CMD_OFF = 1;
  localparam int CMD_CLR = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RAMP, ST_ISOE, ST_REPAIR, ST_OFFE, ST_OFFS
  } seq_state_t;

  typedef enum logic [1:0] {
    FAIL_NONE = 2'd0, FAIL_POWER = 2'd1, FAIL_REPAIR = 2'd2
  } fail_code_t;
endpackage

// File: rtl/pis_regs.sv
module pis_regs
  import pis_pkg::*;
#(
  parameter int AW     = 2,
  parameter int DW     = 32,
  parameter int CW     = 16,
  parameter int DEF_PG = 300,
  parameter int DEF_RP = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  output logic          on_req,
  output logic          off_req,
  output logic [CW-1:0] pg_limit,
  output logic [CW-1:0] rp_limit,
  output logic          collide
);
  localparam int KEY_LSB = DW - 8;

  logic key_ok, cmd_hit, any_cmd;
  assign key_ok  = (wr_data[DW-1:KEY_LSB] == WR_KEY);
  assign cmd_hit = wr_en && key_ok && (wr_addr == AW'(0));
  assign any_cmd = cmd_hit && (wr_data[CMD_ON] || wr_data[CMD_OFF]);
  assign off_req = any_cmd && !busy && wr_data[CMD_OFF];
  assign on_req  = any_cmd && !busy && !wr_data[CMD_OFF];

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_limit <= CW'(DEF_PG);
      rp_limit <= CW'(DEF_RP);
      collide  <= 1'b0;
    end else begin
      if (wr_en && key_ok && wr_addr == AW'(1)) pg_limit <= wr_data[CW-1:0];
      if (wr_en && key_ok && wr_addr == AW'(2)) rp_limit <= wr_data[CW-1:0];
      if (any_cmd && busy) collide <= 1'b1;
      else if (cmd_hit && wr_data[CMD_CLR]) collide <= 1'b0;
    end
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (collide && !(wr_en && key_ok)) |=> collide);
  a_r1_keyless_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !key_ok) |=> ($stable(pg_limit) && $stable(rp_limit) && $stable(collide)));
endmodule

// File: rtl/pis_timer.sv
module pis_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && !expired) |=> (cnt != '0));
endmodule

// File: rtl/pis_ctrl.sv
module pis_ctrl
  import pis_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          on_req,
  input  logic          off_req,
  input  logic          pg_ok,
  input  logic          rep_ok,
  input  logic          expired,
  output logic          tmr_clr,
  output logic          tmr_run,
  output logic          sel_rep,
  output logic          sw_en,
  output logic [IW-1:0] inrush,
  output logic          eiso_rel,
  output logic          fiso_rel,
  output logic          rep_req,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    code
);
  localparam logic [IW-1:0] TOP_LVL = '1;

  seq_state_t state;

  assign busy    = (state != ST_IDLE);
  assign tmr_run = (state == ST_RAMP) || (state == ST_REPAIR);
  assign sel_rep = (state == ST_REPAIR);
  assign tmr_clr = (state == ST_IDLE) || (state == ST_ISOE) ||
                   ((state == ST_RAMP) && !pg_ok && expired);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; sw_en <= 1'b0; inrush <= '0; eiso_rel <= 1'b0;
      fiso_rel <= 1'b0; rep_req <= 1'b0; done <= 1'b0; err <= 1'b0;
      code <= FAIL_NONE;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (off_req) begin
            fiso_rel <= 1'b0; rep_req <= 1'b0; code <= FAIL_NONE; state <= ST_OFFE;
          end else if (on_req) begin
            if (sw_en) done <= 1'b1;
            else begin
              sw_en <= 1'b1; inrush <= '0; code <= FAIL_NONE; state <= ST_RAMP;
            end
          end
        end
        ST_RAMP: begin
          if (pg_ok) begin
            eiso_rel <= 1'b1; state <= ST_ISOE;
          end else if (expired) begin
            if (inrush == TOP_LVL) begin
              sw_en <= 1'b0; inrush <= '0; err <= 1'b1; code <= FAIL_POWER;
              state <= ST_IDLE;
            end else inrush <= inrush + 1'b1;
          end
        end
        ST_ISOE: begin
          rep_req <= 1'b1; state <= ST_REPAIR;
        end
        ST_REPAIR: begin
          if (rep_ok) begin
            rep_req <= 1'b0; fiso_rel <= 1'b1; done <= 1'b1; state <= ST_IDLE;
          end else if (expired) begin
            rep_req <= 1'b0; eiso_rel <= 1'b0; sw_en <= 1'b0; inrush <= '0;
            err <= 1'b1; code <= FAIL_REPAIR; state <= ST_IDLE;
          end
        end
        ST_OFFE: begin
          eiso_rel <= 1'b0; state <= ST_OFFS;
        end
        ST_OFFS: begin
          sw_en <= 1'b0; inrush <= '0; done <= 1'b1; state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_already_on: assert property (@(posedge clk) disable iff (rst)
    (on_req && sw_en) |=> (done && !busy && sw_en && $stable(inrush) && $stable(fiso_rel)));
  a_r3_ramp_up_only: assert property (@(posedge clk) disable iff (rst)
    (busy && sw_en) |=> (!sw_en || inrush >= $past(inrush)));
  a_r4_err_unwound: assert property (@(posedge clk) disable iff (rst)
    err |-> (!sw_en && inrush == '0 && !rep_req));
  a_r5_repair_needs_eiso: assert property (@(posedge clk) disable iff (rst)
    rep_req |-> (eiso_rel && !fiso_rel));
  a_r6_fiso_last: assert property (@(posedge clk) disable iff (rst)
    fiso_rel |-> (eiso_rel && sw_en && !rep_req));
  a_r8_switch_opens_last: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_en) |-> (!eiso_rel && !fiso_rel));
  a_r8_eiso_after_fiso: assert property (@(posedge clk) disable iff (rst)
    $fell(eiso_rel) |-> !fiso_rel);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq #(
  parameter int AW     = 2,
  parameter int DW     = 32,
  parameter int CW     = 16,
  parameter int IW     = 2,
  parameter int DEF_PG = 300,
  parameter int DEF_RP = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pwr_good,
  input  logic          repair_done,
  output logic          sw_enable,
  output logic [IW-1:0] inrush_lvl,
  output logic          eiso_release,
  output logic          fiso_release,
  output logic          repair_req,
  output logic          busy,
  output logic          seq_done,
  output logic          seq_error,
  output logic [1:0]    fail_step,
  output logic          collide
);
  logic on_req, off_req, tmr_clr, tmr_run, sel_rep, expired;
  logic [CW-1:0] pg_limit, rp_limit, cur_limit;

  assign cur_limit = sel_rep ? rp_limit : pg_limit;

  pis_regs #(.AW(AW), .DW(DW), .CW(CW), .DEF_PG(DEF_PG), .DEF_RP(DEF_RP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .on_req(on_req), .off_req(off_req), .pg_limit(pg_limit),
    .rp_limit(rp_limit), .collide(collide));

  pis_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run), .limit(cur_limit),
    .expired(expired));

  pis_ctrl #(.IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req), .pg_ok(pwr_good),
    .rep_ok(repair_done), .expired(expired), .tmr_clr(tmr_clr), .tmr_run(tmr_run),
    .sel_rep(sel_rep), .sw_en(sw_enable), .inrush(inrush_lvl),
    .eiso_rel(eiso_release), .fiso_rel(fiso_release), .rep_req(repair_req),
    .busy(busy), .done(seq_done), .err(seq_error), .code(fail_step));
endmodule

// File: tb/test_pwr_island_seq.sv
module test_pwr_island_seq;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic pwr_good, repair_done;
  logic sw_enable, eiso_release, fiso_release, repair_req, busy, seq_done, seq_error, collide;
  logic [1:0] inrush_lvl, fail_step;

  int checks = 0, errors = 0, cyc = 0;
  int lvl_tgt = 4, pg_dly = 0, rd_dly = 0, lcnt = 0, rcnt = 0;
  int lv[4];
  int rq, e_first, r_first;
  bit fin_done, fin_err;

  always #5 clk = ~clk;

  pwr_island_seq i_pwr_island_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwr_good(pwr_good), .repair_done(repair_done), .sw_enable(sw_enable),
    .inrush_lvl(inrush_lvl), .eiso_release(eiso_release), .fiso_release(fiso_release),
    .repair_req(repair_req), .busy(busy), .seq_done(seq_done), .seq_error(seq_error),
    .fail_step(fail_step), .collide(collide));

  // supply and repair models
  always @(posedge clk) begin
    if (sw_enable && lvl_tgt < 4 && int'(inrush_lvl) == lvl_tgt) lcnt <= lcnt + 1;
    else lcnt <= 0;
    if (repair_req) rcnt <= rcnt + 1;
    else rcnt <= 0;
  end
  always_comb begin
    pwr_good    = sw_enable && lvl_tgt < 4 && int'(inrush_lvl) >= lvl_tgt && lcnt >= pg_dly;
    repair_done = repair_req && rcnt >= rd_dly;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic monitor();
    for (int k = 0; k < 4; k++) lv[k] = 0;
    rq = 0; e_first = -1; r_first = -1; fin_done = 0; fin_err = 0;
    for (int i = 0; i < 3000; i++) begin
      if (sw_enable && busy && !eiso_release) lv[inrush_lvl]++;
      if (repair_req) rq++;
      if (eiso_release && e_first < 0) e_first = i;
      if (repair_req && r_first < 0) r_first = i;
      if (seq_done || seq_error) begin
        fin_done = seq_done; fin_err = seq_error;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic power_off();
    wr(2'd0, 32'h5A00_0002);
    chk(!fiso_release && eiso_release && sw_enable && busy, "R8 step1", int'(fiso_release), 0);
    @(negedge clk);
    chk(!eiso_release && sw_enable && !seq_done, "R8 step2", int'(eiso_release), 0);
    @(negedge clk);
    chk(!sw_enable && seq_done && !busy && inrush_lvl == 2'd0, "R8 step3", int'(sw_enable), 0);
    @(negedge clk);
    chk(!seq_done, "R11 done single", int'(seq_done), 0);
  endtask

  task automatic check_ramp(input int t, input int l, input int d, input string tag);
    bit ok = 1;
    for (int k = 0; k < 4; k++) begin
      int ex = (k < l) ? t + 1 : (k == l ? d + 1 : 0);
      if (lv[k] != ex) begin
        ok = 0;
        chk(0, tag, lv[k], ex);
      end
    end
    if (ok) chk(1, tag, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk({sw_enable, inrush_lvl, eiso_release, fiso_release, repair_req, busy,
         seq_done, seq_error, fail_step, collide} == '0, "R12 reset", int'(sw_enable), 0);

    // R1 keyless commands ignored
    wr(2'd0, 32'h0000_0001);
    chk(!busy && !sw_enable, "R1 no key cmd", int'(busy), 0);
    wr(2'd0, 32'hA500_0001);
    chk(!busy && !sw_enable, "R1 bad key cmd", int'(busy), 0);
    // R1 keyless timeout write: default 300 stays
    wr(2'd1, 32'h5B00_0002);
    lvl_tgt = 1; pg_dly = 0; rd_dly = 1;
    wr(2'd2, 32'h5A00_0003);
    wr(2'd0, 32'h5A00_0001);
    monitor();
    chk(lv[0] == 301, "R1 timeout kept", lv[0], 301);
    power_off();

    // R3 R4 R5 R6 R10 sweep
    for (int t = 0; t < 4; t++) begin
      wr(2'd1, 32'h5A00_0000 | t);
      for (int l = 0; l < 5; l++) begin
        for (int dsel = 0; dsel < 2; dsel++) begin
          if (l == 4 && dsel == 1) continue;
          lvl_tgt = l; pg_dly = dsel ? t : 0; rd_dly = 1;
          wr(2'd0, 32'h5A00_0001);
          monitor();
          if (l == 4) begin
            check_ramp(t, 4, 0, "R3 ramp to top");
            chk(fin_err && !fin_done && fail_step == 2'd1, "R4 power fail", int'(fail_step), 1);
            chk(!sw_enable && inrush_lvl == 2'd0 && !eiso_release, "R4 unwind", int'(sw_enable), 0);
            @(negedge clk);
            chk(!seq_error, "R11 error single", int'(seq_error), 0);
          end else begin
            check_ramp(t, l, pg_dly, dsel ? "R10 expiry tie" : "R3 ramp");
            chk(r_first == e_first + 1, "R5 eiso then repair", r_first, e_first + 1);
            chk(rq == 2, "R6 repair length", rq, 2);
            chk(fin_done && !fin_err && fiso_release && !repair_req && int'(inrush_lvl) == l,
                "R6 finish", int'(fiso_release), 1);
            power_off();
          end
        end
      end
    end

    // R7 repair timing and timeout
    wr(2'd1, 32'h5A00_0002);
    for (int r = 0; r < 5; r++) begin
      lvl_tgt = 0; pg_dly = 0; rd_dly = (r == 4) ? 50 : r;
      wr(2'd0, 32'h5A00_0001);
      monitor();
      if (r == 4) begin
        chk(rq == 4 && fin_err && fail_step == 2'd2, "R7 repair timeout", rq, 4);
        chk(!eiso_release && !sw_enable && inrush_lvl == 2'd0 && !repair_req,
            "R7 unwind", int'(eiso_release), 0);
      end else begin
        chk(rq == r + 1 && fin_done, "R6 repair wait", rq, r + 1);
        if (r == 0) begin
          // R2 power-on while already on
          wr(2'd0, 32'h5A00_0001);
          chk(seq_done && !busy && sw_enable && fiso_release && inrush_lvl == 2'd0,
              "R2 already on", int'(seq_done), 1);
          @(negedge clk);
          chk(!seq_done && !busy, "R2 nothing started", int'(busy), 0);
        end
        power_off();
      end
    end

    // R9 collision during ramp
    wr(2'd1, 32'h5A00_0005);
    lvl_tgt = 2; pg_dly = 0; rd_dly = 1;
    wr(2'd0, 32'h5A00_0001);
    wr(2'd0, 32'h5A00_0002);
    chk(collide == 1'b1, "R9 collision set", int'(collide), 1);
    monitor();
    chk(fin_done && sw_enable && fiso_release, "R9 off ignored", int'(sw_enable), 1);
    wr(2'd0, 32'hA500_0004);
    chk(collide == 1'b1, "R1 R9 keyless clear", int'(collide), 1);
    wr(2'd0, 32'h5A00_0004);
    chk(collide == 1'b0, "R9 cleared", int'(collide), 0);
    power_off();

    // R9 R11 command on the finishing cycle
    lvl_tgt = 0; pg_dly = 0; rd_dly = 2;
    wr(2'd0, 32'h5A00_0001);
    for (int i = 0; i < 100; i++) begin
      if (repair_done) break;
      @(negedge clk);
    end
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h5A00_0002;
    @(negedge clk);
    wr_en = 1'b0;
    chk(seq_done && collide && sw_enable && !seq_error, "R9 finish tie", int'(collide), 1);
    @(negedge clk);
    chk(!busy && fiso_release && sw_enable, "R9 no off started", int'(busy), 0);
    wr(2'd0, 32'h5A00_0004);
    power_off();

    // R9 on and off together while idle -> off
    wr(2'd0, 32'h5A00_0003);
    chk(busy && !sw_enable && !fiso_release, "R9 both bits off", int'(busy), 1);
    repeat (3) @(negedge clk);
    chk(!busy && !sw_enable, "R9 both bits idle", int'(sw_enable), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule